// File: doc/BRIEF.md
# Row float narrowing to half-word lanes

This block takes one row of a two-dimensional tile store, picks a 64-byte window of it, and narrows each of the sixteen 32-bit floating-point elements in that window to a 16-bit float. Each result is placed in either the upper or the lower half of its 32-bit output lane, and the other half is cleared. The 512-bit result is offered on a valid/ready handshake. A 32-bit selector carries two things: the row number in its low half and the window number in its high half.

A request also carries the format and placement choices and the tile's configured row width in bytes. A lane whose source element lies at or past that width is output as all zeros. The block reads the tile through a simple read port that returns a whole row one cycle after the read strobe. Only one request is in flight at a time.

Top module: `row_narrow_unit`

## Requirements
- R1: The row read is taken from selector bits 15:0, truncated to the low ROW_W bits. The single read strobe appears in the cycle after a request is accepted.
- R2: Output lane i (bits 32i+31:32i) takes fp32 element W*16+i of the row, where W is selector bits 31:16. This makes the byte offset W*64.
- R3: A lane whose element index W*16+i is not below colsb/4 (integer division) is output as 32 zero bits. So is a lane whose index lies beyond the row.
- R4: With req_hi=1 every valid lane carries its converted value in bits 31:16 and zero in bits 15:0.
- R5: With req_hi=0 every valid lane carries its converted value in bits 15:0 and zero in bits 31:16.
- R6: With req_fmt=0 (bfloat16) finite values are rounded to nearest, ties to even. Finite values that round beyond the largest bfloat16 become infinity.
- R7: In bfloat16 mode any NaN input gives a NaN with the same sign and the quiet bit (bit 6) set. It is never turned into infinity.
- R8: With req_fmt=1 (IEEE half) values in the normal half range are rounded to nearest, ties to even. A carry out of the mantissa raises the exponent.
- R9: In half mode, magnitudes that round above 65504 become infinity of the same sign. NaN inputs give a quiet half NaN (0x7E00 or 0xFE00 for zero payload).
- R10: In half mode, magnitudes below 2^-14 give half subnormals rounded to nearest even, and may round up to 2^-14. Magnitudes not above 2^-25 become signed zero.
- R11: Signed zeros and infinities keep their sign in both formats.
- R12: Selector, format, placement and width are sampled only in the accept cycle. Changing them afterwards has no effect on that result.
- R13: After reset req_ready=1, res_valid=0 and rd_en=0. While a request is in flight req_ready is 0. The result holds steady with res_valid=1 until res_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | block idle and accepting |
| req_sel | input | 32 | row in bits 15:0, window in bits 31:16 |
| req_fmt | input | 1 | 0 bfloat16, 1 IEEE half |
| req_hi | input | 1 | 1 upper half-word, 0 lower half-word |
| req_colsb | input | CB_W | configured row width in bytes |
| rd_en | output | 1 | tile row read strobe |
| rd_row | output | ROW_W | tile row to read |
| rd_data | input | ROW_BYTES*8 | row contents, valid the cycle after rd_en |
| res_valid | output | 1 | result available |
| res_ready | input | 1 | result taken |
| res_data | output | 512 | sixteen 32-bit output lanes |

## Verification
The bench builds the block with ROW_BYTES=128 and ROWS=8, so each row holds two full windows of real data. With that build, the window offset selects distinct elements, and a width cutoff can fall inside the second window rather than only at the first. Eight rows with a 3-bit row field let a selector whose low half exceeds the row count show the truncation. The directed vectors cover rounding ties, overflow to infinity, NaNs, and the half-subnormal boundary, in both placements.

// File: rtl/rnc_pkg.sv
package rnc_pkg;

    localparam int LANES    = 16;
    localparam int LANE_SH  = $clog2(LANES);
    localparam int OUT_BITS = LANES * 32;

    typedef enum logic { FMT_BF16 = 1'b0, FMT_FP16 = 1'b1 } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CONV = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    // fp32 -> bfloat16, nearest-even; NaNs forced quiet
    function automatic logic [15:0] f32_to_bf16(input logic [31:0] f);
        logic [31:0] sum;
        logic [15:0] r;
        if (f[30:23] == 8'hFF && f[22:0] != 23'd0) begin
            r = {f[31], 8'hFF, 1'b1, f[21:16]};
        end else begin
            sum = f + 32'h0000_7FFF + {31'd0, f[16]};
            r   = sum[31:16];
        end
        return r;
    endfunction

    // fp32 -> IEEE half, nearest-even with subnormal output
    function automatic logic [15:0] f32_to_fp16(input logic [31:0] f);
        logic        s;
        logic [7:0]  e;
        logic [22:0] m;
        logic [15:0] r;
        logic [14:0] mag;
        logic [49:0] shv;
        logic [4:0]  amt;
        logic [10:0] q;
        logic        g;
        logic        st;
        s = f[31];
        e = f[30:23];
        m = f[22:0];
        r = {s, 15'd0};
        if (e == 8'hFF) begin
            r = (m != 23'd0) ? {s, 5'h1F, 1'b1, m[21:13]} : {s, 5'h1F, 10'd0};
        end else if (e >= 8'd143) begin
            r = {s, 5'h1F, 10'd0};
        end else if (e >= 8'd113) begin
            g   = m[12];
            st  = |m[11:0];
            mag = {5'(e - 8'd112), m[22:13]};
            mag = mag + {14'd0, g & (st | m[13])};
            r   = {s, mag};
        end else if (e >= 8'd101) begin
            amt = 5'(8'd126 - e);
            shv = {1'b1, m, 26'd0} >> amt;
            q   = shv[36:26];
            g   = shv[25];
            st  = |shv[24:0];
            q   = q + {10'd0, g & (st | q[0])};
            r   = {s, 4'd0, q};
        end
        return r;
    endfunction

endpackage

// File: rtl/rnc_ctrl.sv
module rnc_ctrl
    import rnc_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int CB_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_sel,
    input  logic             req_fmt,
    input  logic             req_hi,
    input  logic [CB_W-1:0]  req_colsb,
    output logic             rd_en,
    output logic [ROW_W-1:0] rd_row,
    output logic             cap_en,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [15:0]      chunk_q,
    output fmt_e             fmt_q,
    output logic             hi_q,
    output logic [CB_W-1:0]  colsb_q
);

    st_e              state;
    logic [ROW_W-1:0] row_q;
    logic             accept;
    logic             unused_sel;

    assign unused_sel = ^req_sel[15:ROW_W];
    assign accept     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            row_q   <= '0;
            chunk_q <= '0;
            fmt_q   <= FMT_BF16;
            hi_q    <= 1'b0;
            colsb_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state   <= ST_READ;
                    row_q   <= req_sel[ROW_W-1:0];
                    chunk_q <= req_sel[31:16];
                    fmt_q   <= fmt_e'(req_fmt);
                    hi_q    <= req_hi;
                    colsb_q <= req_colsb;
                end
                ST_READ: state <= ST_CONV;
                ST_CONV: state <= ST_DONE;
                ST_DONE: if (res_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rd_en     = (state == ST_READ);
    assign rd_row    = row_q;
    assign cap_en    = (state == ST_CONV);
    assign res_valid = (state == ST_DONE);

    a_r1_read_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> rd_en && rd_row == $past(req_sel[ROW_W-1:0]));

    a_r13_single_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    a_r13_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (rd_en || res_valid) |-> !req_ready);

    a_r12_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(fmt_q) && $stable(hi_q) && $stable(chunk_q) && $stable(colsb_q));

endmodule

// File: rtl/rnc_lane.sv
module rnc_lane
    import rnc_pkg::*;
#(
    parameter int ROW_BYTES = 64,
    parameter int CB_W      = 7,
    parameter int LANE_IDX  = 0
) (
    input  logic [ROW_BYTES*8-1:0] row_data,
    input  logic [15:0]            chunk,
    input  fmt_e                   fmt,
    input  logic                   hi,
    input  logic [CB_W-1:0]        colsb,
    output logic [31:0]            dword
);

    localparam int ELEMS  = ROW_BYTES / 4;
    localparam int ELEM_W = $clog2(ELEMS);
    localparam int IDX_W  = 16 + LANE_SH + 1;

    logic [IDX_W-1:0]  elem;
    logic [ELEM_W-1:0] eidx;
    logic [31:0]       src;
    logic [15:0]       narrow;
    logic              in_range;

    assign elem     = {1'b0, chunk, {LANE_SH{1'b0}}} + IDX_W'(LANE_IDX);
    assign eidx     = elem[ELEM_W-1:0];
    assign in_range = (elem < IDX_W'(colsb >> 2)) && (elem < IDX_W'(ELEMS));
    assign src      = row_data[32*eidx +: 32];

    always_comb begin
        if (fmt == FMT_FP16) narrow = f32_to_fp16(src);
        else                 narrow = f32_to_bf16(src);
    end

    always_comb begin
        if (!in_range) dword = 32'd0;
        else if (hi)   dword = {narrow, 16'd0};
        else           dword = {16'd0, narrow};
    end

endmodule

// File: rtl/row_narrow_unit.sv
module row_narrow_unit
    import rnc_pkg::*;
#(
    parameter int ROW_BYTES = 64,
    parameter int ROWS      = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [31:0]                  req_sel,
    input  logic                         req_fmt,
    input  logic                         req_hi,
    input  logic [$clog2(ROW_BYTES+1)-1:0] req_colsb,
    output logic                         rd_en,
    output logic [$clog2(ROWS)-1:0]      rd_row,
    input  logic [ROW_BYTES*8-1:0]       rd_data,
    output logic                         res_valid,
    input  logic                         res_ready,
    output logic [OUT_BITS-1:0]          res_data
);

    localparam int ROW_W = $clog2(ROWS);
    localparam int CB_W  = $clog2(ROW_BYTES + 1);

    logic                cap_en;
    logic [15:0]         chunk_q;
    fmt_e                fmt_q;
    logic                hi_q;
    logic [CB_W-1:0]     colsb_q;
    logic [OUT_BITS-1:0] lane_vec;
    logic [OUT_BITS-1:0] res_q;

    rnc_ctrl #(.ROW_W(ROW_W), .CB_W(CB_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_sel   (req_sel),
        .req_fmt   (req_fmt),
        .req_hi    (req_hi),
        .req_colsb (req_colsb),
        .rd_en     (rd_en),
        .rd_row    (rd_row),
        .cap_en    (cap_en),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .chunk_q   (chunk_q),
        .fmt_q     (fmt_q),
        .hi_q      (hi_q),
        .colsb_q   (colsb_q)
    );

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        rnc_lane #(.ROW_BYTES(ROW_BYTES), .CB_W(CB_W), .LANE_IDX(li)) u_lane (
            .row_data (rd_data),
            .chunk    (chunk_q),
            .fmt      (fmt_q),
            .hi       (hi_q),
            .colsb    (colsb_q),
            .dword    (lane_vec[32*li +: 32])
        );

        a_r4_low_half_clear: assert property (@(posedge clk) disable iff (rst)
            (res_valid && hi_q) |-> res_data[32*li +: 16] == 16'd0);

        a_r5_high_half_clear: assert property (@(posedge clk) disable iff (rst)
            (res_valid && !hi_q) |-> res_data[32*li+16 +: 16] == 16'd0);
    end

    always_ff @(posedge clk) begin
        if (rst)         res_q <= '0;
        else if (cap_en) res_q <= lane_vec;
    end

    assign res_data = res_q;

    a_r13_result_held: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> res_valid && $stable(res_data));

    a_r3_zero_width: assert property (@(posedge clk) disable iff (rst)
        (res_valid && colsb_q < CB_W'(4)) |-> res_data == '0);

endmodule

// File: tb/row_narrow_unit_bench.sv
`timescale 1ns/1ps
module row_narrow_unit_bench;

    localparam int RB   = 128;
    localparam int NR   = 8;
    localparam int CBW  = $clog2(RB + 1);
    localparam int RW   = $clog2(NR);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     req_sel = '0;
    logic            req_fmt = 1'b0;
    logic            req_hi = 1'b0;
    logic [CBW-1:0]  req_colsb = '0;
    logic            rd_en;
    logic [RW-1:0]   rd_row;
    logic [RB*8-1:0] rd_data = '0;
    logic            res_valid;
    logic            res_ready = 1'b1;
    logic [511:0]    res_data;

    logic [RB*8-1:0] row_mem [NR];
    logic [31:0]     vec [32];
    logic [15:0]     ebf [32];
    logic [15:0]     ehp [32];

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= row_mem[rd_row];

    row_narrow_unit #(.ROW_BYTES(RB), .ROWS(NR)) u_row_narrow_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_fmt(req_fmt), .req_hi(req_hi), .req_colsb(req_colsb),
        .rd_en(rd_en), .rd_row(rd_row), .rd_data(rd_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] elem_exp(input int r, input int k, input bit fmt);
        int idx;
        idx = (r == 3) ? k : (r == 2) ? 31 - k : -1;
        if (idx < 0) return fmt ? 16'h3C00 : 16'h3F80;
        return fmt ? ehp[idx] : ebf[idx];
    endfunction

    function automatic logic [511:0] build(input int r, input int chunk, input bit fmt,
                                           input bit hi, input int cb);
        logic [511:0] v;
        logic [15:0]  h;
        v = '0;
        for (int i = 0; i < 16; i++) begin
            int e;
            e = chunk * 16 + i;
            if (e < cb / 4 && e < 32) begin
                h = elem_exp(r, e, fmt);
                v[32*i +: 32] = hi ? {h, 16'h0} : {16'h0, h};
            end
        end
        return v;
    endfunction

    task automatic run_req(input logic [31:0] sel, input bit fmt, input bit hi,
                           input int cb, input bit scramble, output logic [511:0] res);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_fmt = fmt; req_hi = hi; req_colsb = CBW'(cb);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            req_sel = ~sel; req_fmt = ~fmt; req_hi = ~hi; req_colsb = '0;
        end
        while (!res_valid) @(negedge clk);
        res = res_data;
        @(negedge clk);
    endtask

    task automatic set_v(input int k, input logic [31:0] f, input logic [15:0] b, input logic [15:0] h);
        vec[k] = f; ebf[k] = b; ehp[k] = h;
    endtask

    task automatic t_reset();
        check("R13 reset ready/valid/rd", {509'd0, req_ready, res_valid, rd_en}, {509'd0, 3'b100});
    endtask

    task automatic t_bf16();
        logic [511:0] r;
        run_req({16'd0, 16'd3}, 1'b0, 1'b1, 128, 1'b0, r);
        check("R4 R6 R7 R11 bf16 high", r, build(3, 0, 1'b0, 1'b1, 128));
        run_req({16'd0, 16'd3}, 1'b0, 1'b0, 128, 1'b0, r);
        check("R5 R6 bf16 low", r, build(3, 0, 1'b0, 1'b0, 128));
        run_req({16'd1, 16'd3}, 1'b0, 1'b1, 128, 1'b0, r);
        check("R2 R6 bf16 window1", r, build(3, 1, 1'b0, 1'b1, 128));
    endtask

    task automatic t_fp16();
        logic [511:0] r;
        run_req({16'd0, 16'd3}, 1'b1, 1'b1, 128, 1'b0, r);
        check("R8 R9 R11 fp16 high", r, build(3, 0, 1'b1, 1'b1, 128));
        run_req({16'd1, 16'd3}, 1'b1, 1'b0, 128, 1'b0, r);
        check("R2 R8 R9 R10 fp16 low window1", r, build(3, 1, 1'b1, 1'b0, 128));
    endtask

    task automatic t_width();
        logic [511:0] r;
        run_req({16'd0, 16'd3}, 1'b0, 1'b0, 42, 1'b0, r);
        check("R3 width 42 window0", r, build(3, 0, 1'b0, 1'b0, 42));
        run_req({16'd1, 16'd3}, 1'b1, 1'b1, 72, 1'b0, r);
        check("R3 width 72 window1", r, build(3, 1, 1'b1, 1'b1, 72));
        run_req({16'd2, 16'd3}, 1'b0, 1'b1, 128, 1'b0, r);
        check("R3 window beyond row", r, '0);
        run_req({16'h8001, 16'd3}, 1'b0, 1'b1, 128, 1'b0, r);
        check("R3 huge window", r, '0);
        run_req({16'd0, 16'd3}, 1'b1, 1'b1, 0, 1'b0, r);
        check("R3 width zero", r, '0);
    endtask

    task automatic t_row();
        logic [511:0] r;
        run_req({16'd0, 16'h000A}, 1'b0, 1'b1, 128, 1'b0, r);
        check("R1 row truncation 10->2", r, build(2, 0, 1'b0, 1'b1, 128));
        run_req({16'd1, 16'hFFF3}, 1'b1, 1'b0, 128, 1'b0, r);
        check("R1 row truncation FFF3->3", r, build(3, 1, 1'b1, 1'b0, 128));
    endtask

    task automatic t_capture();
        logic [511:0] r;
        run_req({16'd1, 16'd2}, 1'b1, 1'b1, 100, 1'b1, r);
        check("R12 late input change ignored", r, build(2, 1, 1'b1, 1'b1, 100));
    endtask

    task automatic t_hold();
        logic [511:0] first;
        res_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_sel = {16'd0, 16'd3}; req_fmt = 1'b1; req_hi = 1'b0; req_colsb = CBW'(128);
        @(negedge clk);
        req_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        first = res_data;
        repeat (5) @(negedge clk);
        check("R13 held valid while stalled", {511'd0, res_valid}, {511'd0, 1'b1});
        check("R13 held data while stalled", res_data, first);
        check("R13 not ready while busy", {511'd0, req_ready}, '0);
        check("R8 stalled result value", first, build(3, 0, 1'b1, 1'b0, 128));
        res_ready = 1'b1;
        @(negedge clk);
        check("R13 released after ready", {510'd0, res_valid, req_ready}, {510'd0, 2'b01});
    endtask

    initial begin
        set_v(0,  32'h3F800000, 16'h3F80, 16'h3C00);
        set_v(1,  32'hC0000000, 16'hC000, 16'hC000);
        set_v(2,  32'h3F000000, 16'h3F00, 16'h3800);
        set_v(3,  32'h00000000, 16'h0000, 16'h0000);
        set_v(4,  32'h80000000, 16'h8000, 16'h8000);
        set_v(5,  32'h7F800000, 16'h7F80, 16'h7C00);
        set_v(6,  32'hFF800000, 16'hFF80, 16'hFC00);
        set_v(7,  32'h7FC00000, 16'h7FC0, 16'h7E00);
        set_v(8,  32'h7F800001, 16'h7FC0, 16'h7E00);
        set_v(9,  32'hFF800001, 16'hFFC0, 16'hFE00);
        set_v(10, 32'h3F808000, 16'h3F80, 16'h3C04);
        set_v(11, 32'h3F818000, 16'h3F82, 16'h3C0C);
        set_v(12, 32'h3F808001, 16'h3F81, 16'h3C04);
        set_v(13, 32'h7F7FFFFF, 16'h7F80, 16'h7C00);
        set_v(14, 32'hBF800000, 16'hBF80, 16'hBC00);
        set_v(15, 32'h00000001, 16'h0000, 16'h0000);
        set_v(16, 32'h477FE000, 16'h4780, 16'h7BFF);
        set_v(17, 32'h477FF000, 16'h4780, 16'h7C00);
        set_v(18, 32'h49742400, 16'h4974, 16'h7C00);
        set_v(19, 32'h3F801000, 16'h3F80, 16'h3C00);
        set_v(20, 32'h3F803000, 16'h3F80, 16'h3C02);
        set_v(21, 32'h33800000, 16'h3380, 16'h0001);
        set_v(22, 32'h33000000, 16'h3300, 16'h0000);
        set_v(23, 32'h33400000, 16'h3340, 16'h0001);
        set_v(24, 32'hB2800000, 16'hB280, 16'h8000);
        set_v(25, 32'h387FE000, 16'h3880, 16'h0400);
        set_v(26, 32'h38800000, 16'h3880, 16'h0400);
        set_v(27, 32'hC77FF000, 16'hC780, 16'hFC00);
        set_v(28, 32'hB3400000, 16'hB340, 16'h8001);
        set_v(29, 32'h40490FDB, 16'h4049, 16'h4248);
        set_v(30, 32'h3DCCCCCD, 16'h3DCD, 16'h2E66);
        set_v(31, 32'hC2F6E979, 16'hC2F7, 16'hD7B7);
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < 32; k++)
                row_mem[r][32*k +: 32] = (r == 3) ? vec[k] : (r == 2) ? vec[31-k] : 32'h3F800000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bf16();
        t_fp16();
        t_width();
        t_row();
        t_capture();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R13 watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule